// File: doc/BRIEF.md
# Single-Step Non-Restoring Division Unit

This block performs one iteration of a bit-serial non-restoring division each time it is strobed. It holds three status bits: the quotient-sign bit Q, the divisor-sign bit M and the condition bit T. A step takes the current partial remainder on `rem_i` and the divisor on `divisor_i`. It shifts the remainder left and feeds T into the vacated bit. It then adds or subtracts the divisor, depending on whether the old Q matches M. The step registers the new remainder together with the new Q and T.

Software drives the full division. It issues a setup command first: an unsigned setup clears Q, M and T, and a signed setup loads them from the operand signs. It then issues one step per quotient bit and rotates the low dividend word through T between steps. To save a cycle per bit, a T write can be issued in the same cycle as a step. In that case the written value feeds the step, so the rotate and the divide step fuse into one cycle.

Top module: `nrdiv_step`

## Requirements
- R1: After reset `rem_o`, `q_o`, `m_o` and `t_o` are all 0.
- R2: An unsigned setup (`init_u_i` high, `init_s_i` low) clears Q, M and T on the next edge and leaves `rem_o` unchanged.
- R3: A signed setup (`init_s_i` high) sets Q to `rem_i[31]`, M to `divisor_i[31]` and T to Q XOR M; `rem_o` is unchanged.
- R4: A step forms S = {`rem_i[30:0]`, Tin}, where Tin is `t_in` when `t_wr_i` is high and the held T otherwise. It registers S − divisor when the old Q equals M and S + divisor when they differ, keeping 32 bits.
- R5: On a subtracting step, let B be the borrow out of the 32-bit subtraction. The new Q is `rem_i[31]` XOR B when the old Q is 0, and the inverse of that when the old Q is 1.
- R6: On an adding step, let C be the carry out of the 32-bit addition. The new Q is the inverse of (`rem_i[31]` XOR C) when the old Q is 0, and `rem_i[31]` XOR C when the old Q is 1.
- R7: After a step, T is 1 exactly when the new Q equals M, and M keeps its value.
- R8: A T write (`t_wr_i` high with no step or setup) loads T from `t_in` and leaves Q, M and `rem_o` unchanged.
- R9: When a T write and a step fall in the same cycle, `t_in` fills bit 0 of the shifted remainder and the final T is the one the step produces.
- R10: A setup in the same cycle as a step or a T write wins: the step and the T write are ignored and `rem_o` is unchanged. A signed setup takes precedence over an unsigned one.
- R11: An unsigned setup followed by 32 fused rotate-and-step cycles, plus a final rotate, leaves the quotient of a 64-by-32 unsigned division in the rotated low word whenever the high word is below the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Perform one division step this cycle |
| init_u_i | input | 1 | Unsigned setup command |
| init_s_i | input | 1 | Signed setup command |
| t_wr_i | input | 1 | Write T from `t_in` |
| t_in | input | 1 | Value for a T write |
| divisor_i | input | 32 | Divisor |
| rem_i | input | 32 | Current partial remainder or dividend high word |
| rem_o | output | 32 | Registered partial remainder from the last step |
| q_o | output | 1 | Q status bit |
| m_o | output | 1 | M status bit |
| t_o | output | 1 | T status bit |

## Verification
Two functions can be active in the same cycle: the T write and the step, and a setup with either of them. The bench raises `t_wr_i` and `step_i` together with a `t_in` that differs from the held T. It checks that bit 0 of the result follows `t_in` and that the final T follows the step rule. It also raises setup and step together and checks that `rem_o` holds and the setup values land. The full unsigned division runs entirely on fused rotate-and-step cycles, so the bench judges the collision again through the quotient.

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         init_u_i,
  input  logic         init_s_i,
  input  logic         t_wr_i,
  input  logic         t_in,
  input  logic [W-1:0] divisor_i,
  input  logic [W-1:0] rem_i,
  output logic [W-1:0] rem_o,
  output logic         q_o,
  output logic         m_o,
  output logic         t_o
);

  logic         q_r, m_r, t_r;
  logic [W-1:0] rem_r;

  logic         t_src;
  logic [W-1:0] shifted;
  logic         msb;
  logic         do_sub;
  logic [W:0]   sub_x;
  logic [W:0]   add_x;
  logic         q_sub, q_add, q_nxt;
  logic         init_any;

  assign init_any = init_u_i | init_s_i;
  assign t_src    = t_wr_i ? t_in : t_r;
  assign shifted  = {rem_i[W-2:0], t_src};
  assign msb      = rem_i[W-1];
  assign do_sub   = (q_r == m_r);

  assign sub_x = {1'b0, shifted} - {1'b0, divisor_i};
  assign add_x = {1'b0, shifted} + {1'b0, divisor_i};

  // subtract: old Q=0 -> msb^borrow, old Q=1 -> inverted
  assign q_sub = msb ^ sub_x[W] ^ q_r;
  // add: old Q=0 -> inverted msb^carry, old Q=1 -> msb^carry
  assign q_add = ~(msb ^ add_x[W] ^ q_r);
  assign q_nxt = do_sub ? q_sub : q_add;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= 1'b0;
      m_r   <= 1'b0;
      t_r   <= 1'b0;
      rem_r <= '0;
    end else if (init_s_i) begin
      q_r <= rem_i[W-1];
      m_r <= divisor_i[W-1];
      t_r <= rem_i[W-1] ^ divisor_i[W-1];
    end else if (init_u_i) begin
      q_r <= 1'b0;
      m_r <= 1'b0;
      t_r <= 1'b0;
    end else if (step_i) begin
      q_r   <= q_nxt;
      t_r   <= (q_nxt == m_r);
      rem_r <= do_sub ? sub_x[W-1:0] : add_x[W-1:0];
    end else if (t_wr_i) begin
      t_r <= t_in;
    end
  end

  assign rem_o = rem_r;
  assign q_o   = q_r;
  assign m_o   = m_r;
  assign t_o   = t_r;

  logic unused_ok;
  assign unused_ok = init_any;

endmodule

// File: rtl/nrdiv_step_chk.sv
module nrdiv_step_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step_i,
  input logic         init_u_i,
  input logic         init_s_i,
  input logic         t_wr_i,
  input logic         t_in,
  input logic [W-1:0] divisor_i,
  input logic [W-1:0] rem_i,
  input logic [W-1:0] rem_o,
  input logic         q_o,
  input logic         m_o,
  input logic         t_o
);

  assert_unsigned_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_u_i && !init_s_i) |=> (!q_o && !m_o && !t_o));

  assert_signed_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_s_i |=> (q_o == $past(rem_i[W-1]) && m_o == $past(divisor_i[W-1]) && t_o == (q_o ^ m_o)));

  assert_low_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_u_i && !init_s_i) |=>
      rem_o[0] == (($past(t_wr_i) ? $past(t_in) : $past(t_o)) ^ $past(divisor_i[0])));

  assert_t_tracks_q_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_u_i && !init_s_i) |=> (t_o == (q_o == m_o)));

  assert_m_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_u_i && !init_s_i) |=> $stable(m_o));

  assert_t_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (t_wr_i && !step_i && !init_u_i && !init_s_i) |=> (t_o == $past(t_in) && $stable(q_o) && $stable(m_o)));

  assert_rem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i || init_u_i || init_s_i) |=> $stable(rem_o));

endmodule

bind nrdiv_step nrdiv_step_chk #(.W(W)) u_chk (.*);

// File: tb/nrdiv_step_tb.sv
module nrdiv_step_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0, init_u_i = 1'b0, init_s_i = 1'b0, t_wr_i = 1'b0, t_in = 1'b0;
  logic [31:0] divisor_i = '0, rem_i = '0;
  logic [31:0] rem_o;
  logic        q_o, m_o, t_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nrdiv_step u_dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .init_u_i(init_u_i),
    .init_s_i(init_s_i), .t_wr_i(t_wr_i), .t_in(t_in),
    .divisor_i(divisor_i), .rem_i(rem_i), .rem_o(rem_o),
    .q_o(q_o), .m_o(m_o), .t_o(t_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive on falling edge, return just after the next rising edge
  task automatic cyc(input logic st, input logic iu, input logic is,
                     input logic tw, input logic ti,
                     input logic [31:0] dv, input logic [31:0] rm);
    @(negedge clk);
    step_i = st; init_u_i = iu; init_s_i = is; t_wr_i = tw; t_in = ti;
    divisor_i = dv; rem_i = rm;
    @(posedge clk);
    #1;
    step_i = 1'b0; init_u_i = 1'b0; init_s_i = 1'b0; t_wr_i = 1'b0;
  endtask

  // reference step from the requirement text; returns {rem, q, t}
  function automatic logic [33:0] ref_step(input logic [31:0] rm, input logic [31:0] dv,
                                           input logic q, input logic m, input logic tin);
    logic [32:0] s;
    logic [32:0] r;
    logic nq;
    s = {1'b0, rm[30:0], tin};
    if (q == m) begin
      r  = s - {1'b0, dv};
      nq = (rm[31] ^ r[32]);
      if (q) nq = ~nq;
    end else begin
      r  = s + {1'b0, dv};
      nq = (rm[31] ^ r[32]);
      if (!q) nq = ~nq;
    end
    return {r[31:0], nq, (nq == m)};
  endfunction

  task automatic test_reset();
    chk("R1 rem", rem_o, 0);
    chk("R1 qmt", {q_o, m_o, t_o}, 0);
  endtask

  task automatic test_signed_setup();
    cyc(0, 0, 1, 0, 0, 32'h1234_5678, 32'h8000_0000);
    chk("R3 q1 m0", {q_o, m_o, t_o}, 3'b101);
    cyc(0, 0, 1, 0, 0, 32'h8000_0001, 32'h0000_0001);
    chk("R3 q0 m1", {q_o, m_o, t_o}, 3'b011);
    cyc(0, 0, 1, 0, 0, 32'hF000_0000, 32'hC000_0000);
    chk("R3 q1 m1", {q_o, m_o, t_o}, 3'b110);
    chk("R3 rem unchanged", rem_o, 0);
  endtask

  task automatic test_unsigned_setup();
    cyc(0, 1, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R2 clear", {q_o, m_o, t_o}, 0);
    chk("R2 rem unchanged", rem_o, 0);
  endtask

  // set Q/M by signed setup, then one step, compare with model
  task automatic one_step(input string req, input logic qs, input logic ms,
                          input logic [31:0] dv, input logic [31:0] rm);
    logic [33:0] e;
    logic tcur;
    cyc(0, 0, 1, 0, 0, {ms, 31'h0}, {qs, 31'h0});
    tcur = t_o;
    e = ref_step(rm, dv, q_o, m_o, tcur);
    cyc(1, 0, 0, 0, 0, dv, rm);
    chk({req, " rem"}, rem_o, e[33:2]);
    chk({req, " q"}, q_o, e[1]);
    chk({req, " t R7"}, t_o, e[0]);
    chk({req, " m held R7"}, m_o, ms);
  endtask

  task automatic test_steps();
    one_step("R4 R5 sub q0 borrow", 0, 0, 32'h9000_0000, 32'h4000_0000);
    one_step("R5 sub q0 noborrow", 0, 0, 32'h0000_0003, 32'hC000_0005);
    one_step("R5 sub q1", 1, 1, 32'hFFFF_FFF0, 32'hA123_4567);
    one_step("R5 sub q1 b", 1, 1, 32'h8000_0000, 32'h0FFF_FFFF);
    one_step("R6 add q0", 0, 1, 32'h8000_0001, 32'h7FFF_FFFF);
    one_step("R6 add q0 nc", 0, 1, 32'h0000_0010, 32'h1234_0000);
    one_step("R6 add q1", 1, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    one_step("R6 add q1 nc", 1, 0, 32'h0000_0001, 32'h0000_0000);
  endtask

  task automatic test_t_write();
    logic [31:0] r0;
    logic q0, m0;
    r0 = rem_o; q0 = q_o; m0 = m_o;
    cyc(0, 0, 0, 1, ~t_o, 32'h5555_5555, 32'hAAAA_AAAA);
    chk("R8 t loaded", t_o, ~t_o ? 1'b0 : 1'b0 | t_in);
    chk("R8 q m held", {q_o, m_o}, {q0, m0});
    chk("R8 rem held", rem_o, r0);
  endtask

  task automatic test_collision();
    logic [33:0] e;
    cyc(0, 1, 0, 0, 0, 0, 0);                 // Q=M=T=0
    e = ref_step(32'h0000_0010, 32'h0000_0001, 0, 0, 1'b1);
    cyc(1, 0, 0, 1, 1, 32'h0000_0001, 32'h0000_0010);
    chk("R9 bit0 from t_in", rem_o, e[33:2]);
    chk("R9 final t from step", t_o, e[0]);
    chk("R9 q", q_o, e[1]);
  endtask

  task automatic test_setup_wins();
    logic [31:0] r0;
    r0 = rem_o;
    cyc(1, 0, 1, 1, 0, 32'h8000_0000, 32'h0000_0000);
    chk("R10 signed wins", {q_o, m_o, t_o}, 3'b011);
    chk("R10 rem held", rem_o, r0);
    cyc(1, 1, 1, 0, 0, 32'h0000_0000, 32'h8000_0000);
    chk("R10 signed over unsigned", {q_o, m_o, t_o}, 3'b101);
    cyc(1, 1, 0, 1, 1, 32'h1, 32'h1);
    chk("R10 unsigned wins", {q_o, m_o, t_o}, 3'b000);
    chk("R10 rem held u", rem_o, r0);
  endtask

  task automatic run_div(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] dv);
    logic [31:0] h, l;
    logic [63:0] expq;
    logic tb;
    h = hi; l = lo;
    cyc(0, 1, 0, 0, 0, dv, 0);
    for (int k = 0; k < 32; k++) begin
      tb = t_o;
      cyc(1, 0, 0, 1, l[31], dv, h);
      l = {l[30:0], tb};
      h = rem_o;
    end
    l = {l[30:0], t_o};
    expq = {hi, lo} / {32'h0, dv};
    chk("R11 quotient", l, expq);
  endtask

  task automatic test_divide();
    run_div(32'h0, 32'd100, 32'd7);
    run_div(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_div(32'h0, 32'hFFFF_FFFF, 32'h1);
    run_div(32'h0000_0001, 32'h0, 32'h2);
    for (int i = 0; i < 20; i++) begin
      logic [31:0] d, h;
      d = $urandom;
      if (d == 0) d = 32'd3;
      h = $urandom % d;
      run_div(h, $urandom, d);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    test_signed_setup();
    test_unsigned_setup();
    test_steps();
    test_t_write();
    test_collision();
    test_setup_wins();
    test_divide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule